// File: doc/BRIEF.md
# Resource-List World-Wide-Name Finder

This block walks a list of self-describing records held in the first bytes of a nonvolatile configuration image and pulls out the 64-bit world-wide name that sits inside one nested record. A pulse on `start` begins a scan from byte 0. The block fetches bytes through a synchronous read port: it drives an address with `rd_en`, and the byte comes back on `rd_data` in the next cycle. It then decodes record headers of two shapes. A one-byte header carries a 3-bit length. A three-byte header carries a 16-bit little-endian length.

Records of one particular long type are opened, and the subrecords inside them are searched for the name tag. The scan ends at the first name found, at an end-of-list record, or at the first read that would fall outside the scan window. A one-cycle `done` pulse then reports the found flag, the eight name bytes and the byte offset of the first name byte. The results hold until the next scan begins.

Top module: `tlv_wwn_finder`

## Requirements
- R1: When idle (`busy` low), a `start` pulse begins a scan at byte 0 and raises `busy` in the next cycle. `busy` stays high until the cycle in which `done` pulses. A `start` seen while `busy` is high is ignored and does not restart the scan.
- R2: Each read drives `rd_en` high with `rd_addr` for one cycle and uses `rd_data` in the following cycle. No read is issued while idle.
- R3: A header byte with bit 7 equal to 0 is a short record. Bits 6:3 hold its type, and its total length is 1 plus bits 2:0. The next header follows directly after it.
- R4: A short record of type 0xF (header bytes 0x78 to 0x7F) ends the list. The scan finishes with not-found, and records after it are never examined.
- R5: A header byte with bit 7 equal to 1 is a long record. Bits 6:0 hold its type. Its total length is 3 plus the 16-bit value formed from the next byte (low) and the byte after that (high).
- R6: Inside a long record of type 0x0D, subrecords start 3 bytes after the header. In each subrecord, bits 5:0 of the first byte are its type, and its next two bytes are a little-endian payload length. The walk advances by that length plus 3 while it stays below the record end, then resumes with the header that follows the record. A subrecord inside a long record of any other type is never examined.
- R7: The first subrecord of type 0x3C supplies the name: its first 8 payload bytes. The byte at the lower address is placed in bits 63:56 of `wwn`. `wwn_offset` is the subrecord start plus 3, `found` is 1, and the scan stops.
- R8: When no name is found, `found`, `wwn_offset` and `wwn` are all 0 at `done`.
- R9: Any read address at or beyond the 128-byte window ends the scan with not-found. This covers a header position, length bytes and name bytes.
- R10: `done` is high for exactly one cycle per scan. `found`, `wwn` and `wwn_offset` are valid with it and hold their values until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| rd_en | output | 1 | Read request to the image memory |
| rd_addr | output | AW (7) | Byte address of the read |
| rd_data | input | 8 | Byte returned one cycle after the request |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle end-of-scan pulse |
| found | output | 1 | Name located |
| wwn | output | 64 | Name bytes, lowest address in bits 63:56 |
| wwn_offset | output | AW (7) | Offset of the first name byte, 0 when not found |

## Verification
Two walks can end in the same cycle: the subrecord walk can run out at exactly the byte where the enclosing record ends, and the outer walk must then fetch the next header from that same address. Random images are built so that the last subrecord sometimes fills its record exactly, sometimes falls short, and sometimes overruns it through a corrupt length. A second collision is between a name that would be complete and the window limit: the last name byte is placed at byte 127 in one case and at byte 128 in another. Every result is judged against a bench model that applies the record rules to the same image.

// File: rtl/tlv_pkg.sv
// Shared types and constants for the resource-list name finder.
// Assumes a byte-wide image with the record layout described in the brief.
package tlv_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for start
        ST_HDR,    // record header byte
        ST_LLO,    // long record length, low byte
        ST_LHI,    // long record length, high byte
        ST_SHDR,   // subrecord type byte
        ST_SLO,    // subrecord length, low byte
        ST_SHI,    // subrecord length, high byte
        ST_NAME    // name payload bytes
    } step_t;

    localparam logic [3:0] END_TYPE  = 4'hF;
    localparam logic [6:0] NEST_TYPE = 7'h0D;
    localparam logic [5:0] NAME_TAG  = 6'h3C;
endpackage

// File: rtl/tlv_hdr_decode.sv
// Splits a header byte into its short/long fields and subrecord type.
// Purely combinational; the caller decides which view applies.
module tlv_hdr_decode (
    input  logic [7:0] hdr,
    output logic       is_long,
    output logic [3:0] short_type,
    output logic [3:0] short_len,
    output logic [6:0] long_type,
    output logic [5:0] sub_type
);
    // Field extraction for both header shapes.
    always_comb begin
        is_long    = hdr[7];
        short_type = hdr[6:3];
        short_len  = 4'd1 + {1'b0, hdr[2:0]};
        long_type  = hdr[6:0];
        sub_type   = hdr[5:0];
    end
endmodule

// File: rtl/tlv_addr_guard.sv
// Compares a wide fetch pointer against the scan window.
// Assumes LIMIT fits in PW bits.
module tlv_addr_guard #(
    parameter int PW    = 25,
    parameter int LIMIT = 128
) (
    input  logic [PW-1:0] addr,
    output logic          in_range
);
    localparam logic [PW-1:0] LIM = PW'(LIMIT);

    // Window check on the untruncated pointer.
    always_comb in_range = (addr < LIM);
endmodule

// File: rtl/tlv_wwn_collect.sv
// Assembles the name bytes in arrival order, first byte ending in the top lane.
// Assumes clr and shift_en are never high together.
module tlv_wwn_collect #(
    parameter int NB = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          shift_en,
    input  logic [7:0]    byte_in,
    output logic [8*NB-1:0] name
);
    // Shift register for the name bytes.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) name <= '0;
        else if (shift_en) name <= {name[8*NB-9:0], byte_in};
    end

    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !shift_en) |=> (name == '0));
endmodule

// File: rtl/tlv_wwn_finder.sv
// Top: walks the record list through a one-cycle-latency read port and
// reports the first nested name record. Each fetch takes two cycles:
// a request cycle (address checked against the window) and a use cycle.
module tlv_wwn_finder #(
    parameter int AW    = 7,
    parameter int LIMIT = 128,
    parameter int NB    = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    output logic            rd_en,
    output logic [AW-1:0]   rd_addr,
    input  logic [7:0]      rd_data,
    output logic            busy,
    output logic            done,
    output logic            found,
    output logic [8*NB-1:0] wwn,
    output logic [AW-1:0]   wwn_offset
);
    import tlv_pkg::*;

    localparam int PW = AW + 18;
    localparam int CW = $clog2(NB);
    localparam logic [CW-1:0] LAST = CW'(NB - 1);

    step_t         step_q;
    logic          wait_q;
    logic [PW-1:0] fetch_q, rec_q, end_q, sub_q;
    logic [7:0]    lo_q;
    logic [6:0]    ltype_q;
    logic [5:0]    stype_q;
    logic [CW-1:0] cnt_q;
    logic          done_q, found_q;
    logic [AW-1:0] off_q;

    logic          is_long;
    logic [3:0]    short_type, short_len;
    logic [6:0]    long_type;
    logic [5:0]    sub_type;
    logic          in_range;
    logic          accept, use_cyc, miss_end, name_shift;
    logic [PW-1:0] len16, rec_next, sub_next;

    tlv_hdr_decode u_dec (
        .hdr(rd_data), .is_long(is_long), .short_type(short_type),
        .short_len(short_len), .long_type(long_type), .sub_type(sub_type)
    );

    tlv_addr_guard #(.PW(PW), .LIMIT(LIMIT)) u_guard (
        .addr(fetch_q), .in_range(in_range)
    );

    // Control strobes and pointer arithmetic for the use cycle.
    always_comb begin
        accept     = (step_q == ST_IDLE) && start;
        use_cyc    = (step_q != ST_IDLE) && wait_q;
        len16      = PW'({rd_data, lo_q});
        rec_next   = rec_q + PW'(3) + len16;
        sub_next   = sub_q + PW'(3) + len16;
        miss_end   = ((step_q != ST_IDLE) && !wait_q && !in_range) ||
                     (use_cyc && step_q == ST_HDR && !is_long &&
                      short_type == END_TYPE);
        name_shift = use_cyc && step_q == ST_NAME;
    end

    tlv_wwn_collect #(.NB(NB)) u_col (
        .clk(clk), .rst_n(rst_n), .clr(accept || miss_end),
        .shift_en(name_shift), .byte_in(rd_data), .name(wwn)
    );

    // Scan sequencer: request/use alternation and record walking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q  <= ST_IDLE;
            wait_q  <= 1'b0;
            fetch_q <= '0;
            rec_q   <= '0;
            end_q   <= '0;
            sub_q   <= '0;
            lo_q    <= '0;
            ltype_q <= '0;
            stype_q <= '0;
            cnt_q   <= '0;
            done_q  <= 1'b0;
            found_q <= 1'b0;
            off_q   <= '0;
        end else begin
            done_q <= 1'b0;
            if (accept) begin
                step_q  <= ST_HDR;
                wait_q  <= 1'b0;
                fetch_q <= '0;
                rec_q   <= '0;
                found_q <= 1'b0;
                off_q   <= '0;
            end else if (miss_end) begin
                step_q <= ST_IDLE;
                wait_q <= 1'b0;
                done_q <= 1'b1;
            end else if (step_q != ST_IDLE && !wait_q) begin
                wait_q <= 1'b1;
            end else if (use_cyc) begin
                wait_q <= 1'b0;
                case (step_q)
                    ST_HDR: begin
                        if (is_long) begin
                            ltype_q <= long_type;
                            fetch_q <= rec_q + PW'(1);
                            step_q  <= ST_LLO;
                        end else begin
                            rec_q   <= rec_q + PW'(short_len);
                            fetch_q <= rec_q + PW'(short_len);
                        end
                    end
                    ST_LLO: begin
                        lo_q    <= rd_data;
                        fetch_q <= fetch_q + PW'(1);
                        step_q  <= ST_LHI;
                    end
                    ST_LHI: begin
                        end_q <= rec_next;
                        if (ltype_q == NEST_TYPE && len16 != '0) begin
                            sub_q   <= rec_q + PW'(3);
                            fetch_q <= rec_q + PW'(3);
                            step_q  <= ST_SHDR;
                        end else begin
                            rec_q   <= rec_next;
                            fetch_q <= rec_next;
                            step_q  <= ST_HDR;
                        end
                    end
                    ST_SHDR: begin
                        stype_q <= sub_type;
                        fetch_q <= fetch_q + PW'(1);
                        step_q  <= ST_SLO;
                    end
                    ST_SLO: begin
                        lo_q    <= rd_data;
                        fetch_q <= fetch_q + PW'(1);
                        step_q  <= ST_SHI;
                    end
                    ST_SHI: begin
                        if (stype_q == NAME_TAG) begin
                            cnt_q   <= '0;
                            fetch_q <= sub_q + PW'(3);
                            step_q  <= ST_NAME;
                        end else if (sub_next < end_q) begin
                            sub_q   <= sub_next;
                            fetch_q <= sub_next;
                            step_q  <= ST_SHDR;
                        end else begin
                            rec_q   <= end_q;
                            fetch_q <= end_q;
                            step_q  <= ST_HDR;
                        end
                    end
                    ST_NAME: begin
                        if (cnt_q == LAST) begin
                            step_q  <= ST_IDLE;
                            done_q  <= 1'b1;
                            found_q <= 1'b1;
                            off_q   <= AW'(sub_q + PW'(3));
                        end else begin
                            cnt_q   <= cnt_q + CW'(1);
                            fetch_q <= fetch_q + PW'(1);
                        end
                    end
                    default: step_q <= ST_IDLE;
                endcase
            end
        end
    end

    // Port drive.
    always_comb begin
        busy       = (step_q != ST_IDLE);
        rd_en      = busy && !wait_q && in_range;
        rd_addr    = fetch_q[AW-1:0];
        done       = done_q;
        found      = found_q;
        wwn_offset = off_q;
    end

    p_start_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);
    p_idle_no_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en);
    p_read_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> !rd_en);
    p_hit_offset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && found) |-> (wwn_offset >= AW'(3)));
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !found) |-> (wwn_offset == '0 && wwn == '0));
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
endmodule

// File: tb/test_tlv_wwn_finder.sv
module test_tlv_wwn_finder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        rd_en;
    logic [6:0]  rd_addr;
    logic [7:0]  rd_data;
    logic        busy, done, found;
    logic [63:0] wwn;
    logic [6:0]  wwn_offset;
    logic [7:0]  mem [0:127];
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

    tlv_wwn_finder i_tlv_wwn_finder (
        .clk(clk), .rst_n(rst_n), .start(start), .rd_en(rd_en),
        .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .found(found), .wwn(wwn), .wwn_offset(wwn_offset)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int b(input int i);
        return int'(mem[i]);
    endfunction

    // Model of the record rules over the bench image.
    function automatic void ref_scan(output bit f, output logic [63:0] w, output int off);
        int p = 0;
        f = 0; w = '0; off = 0;
        while (1) begin
            if (p >= 128) return;
            if (!mem[p][7]) begin
                if (mem[p][6:3] == 4'hF) return;
                p += 1 + int'(mem[p][2:0]);
            end else begin
                int e;
                if (p + 2 >= 128) return;
                e = p + 3 + b(p+1) + 256 * b(p+2);
                if (mem[p][6:0] == 7'h0D) begin
                    int s = p + 3;
                    while (s < e) begin
                        if (s + 2 >= 128) return;
                        if (mem[s][5:0] == 6'h3C) begin
                            if (s + 10 >= 128) return;
                            for (int k = 0; k < 8; k++) w = {w[55:0], mem[s+3+k]};
                            f = 1; off = s + 3;
                            return;
                        end
                        s += 3 + b(s+1) + 256 * b(s+2);
                    end
                end
                p = e;
            end
        end
    endfunction

    task automatic put(input int i, input int v);
        if (i < 128) mem[i] = v[7:0];
    endtask

    task automatic fill(input int v);
        for (int i = 0; i < 128; i++) mem[i] = v[7:0];
    endtask

    // Random but mostly well-formed record list.
    task automatic build_random();
        int p = 0;
        for (int i = 0; i < 128; i++) mem[i] = 8'($urandom);
        while (p < 124) begin
            int kind = $urandom_range(0, 9);
            if (kind <= 2) begin
                int l = $urandom_range(0, 7);
                put(p, {1'b0, 4'($urandom_range(0, 14)), 3'(l)});
                p += 1 + l;
            end else if (kind == 3) begin
                if ($urandom_range(0, 2) == 0) put(p, 8'h78 | $urandom_range(0, 7));
                p += 1;
            end else if (kind == 4) begin
                int l = $urandom_range(0, 9);
                put(p, 8'h80 | $urandom_range(0, 127)); put(p+1, l); put(p+2, 0);
                put(p+3, 8'hFC);
                p += 3 + l;
            end else begin
                int s = p + 3;
                int tot = 0;
                int nsub = $urandom_range(0, 3);
                put(p, (kind == 9) ? 8'h8E : 8'h8D);
                for (int k = 0; k < nsub; k++) begin
                    int l = ($urandom_range(0, 2) == 0) ? 8 : $urandom_range(0, 5);
                    put(s, (l == 8 && $urandom_range(0, 1) == 1) ?
                           ($urandom_range(0, 1) ? 8'h3C : 8'hFC) : $urandom_range(0, 59));
                    put(s+1, l); put(s+2, 0);
                    s += 3 + l; tot += 3 + l;
                end
                tot += $urandom_range(0, 4) - 2;
                if (tot < 0) tot = 0;
                put(p+1, tot); put(p+2, 0);
                p += 3 + tot;
            end
        end
    endtask

    // One scan: start, optional second start while busy, compare against model.
    task automatic run_scan(input string tag, input bit poke);
        bit ef; logic [63:0] ew; int eo; int dn = 0; int cyc = 0;
        ref_scan(ef, ew, eo);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({tag, " R1 busy after start"}, busy, 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; @(negedge clk); start = 1'b0;
        end
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL %s R10 watchdog: actual no done expected done", tag);
            return;
        end
        chk({tag, " R7/R8 found"}, found, ef);
        chk({tag, " R7/R8 wwn"}, wwn, ew);
        chk({tag, " R7/R8 offset"}, wwn_offset, eo);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (done) dn++;
        end
        chk({tag, " R10 single done"}, dn, 0);
        chk({tag, " R1 idle after done"}, busy, 0);
        chk({tag, " R10 hold offset"}, wwn_offset, eo);
    endtask

    initial begin
        void'($urandom(32'h5EED_0123));
        fill(0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset busy", busy, 0);
        chk("R10 reset done", done, 0);
        chk("R8 reset found", found, 0);
        chk("R8 reset wwn", wwn, 0);
        chk("R2 reset no read", rd_en, 0);

        // R3 R9: zero image walks 1-byte short records past the window.
        fill(0);
        run_scan("D1 R3 R9 zeros", 0);

        // R4: end record before a valid name record.
        fill(0);
        put(0, 8'h7B); put(1, 8'h8D); put(2, 11); put(3, 0); put(4, 8'h3C); put(5, 8);
        run_scan("D2 R4 end first", 0);
        chk("D2 R4 not found", found, 0);

        // R3 R5 R6 R7: short record, then nest with a non-tag sub and a masked tag.
        fill(0);
        put(0, 8'h0A); put(1, 8'hEE); put(2, 8'hEE);
        put(3, 8'h8D); put(4, 16); put(5, 0);
        put(6, 8'h05); put(7, 2); put(8, 0); put(9, 8'h3C); put(10, 8'h3C);
        put(11, 8'hFC); put(12, 8); put(13, 0);
        for (int k = 0; k < 8; k++) put(14 + k, 8'h11 * (k + 1));
        run_scan("D3 R6 nested", 1);
        chk("D3 R7 offset 14", wwn_offset, 14);
        chk("D3 R7 byte order", wwn, 64'h1122334455667788);

        // R6: tag inside a long record of another type is skipped.
        fill(0);
        put(0, 8'h8E); put(1, 11); put(2, 0); put(3, 8'h3C); put(4, 8); put(5, 0);
        run_scan("D4 R6 other type", 0);
        chk("D4 R6 not found", found, 0);

        // R9: last name byte at 127 succeeds, at 128 fails.
        fill(0);
        put(114, 8'h8D); put(115, 11); put(116, 0); put(117, 8'h3C); put(118, 8); put(119, 0);
        for (int k = 0; k < 8; k++) put(120 + k, 8'hA0 + k);
        run_scan("D5 R9 edge in", 0);
        chk("D5 R9 found at edge", found, 1);
        fill(0);
        put(115, 8'h8D); put(116, 11); put(117, 0); put(118, 8'h3C); put(119, 8); put(120, 0);
        run_scan("D6 R9 edge out", 0);
        chk("D6 R9 not found past edge", found, 0);

        // R5 R9: long length pointing far past the window.
        fill(0);
        put(0, 8'hA2); put(1, 8'h00); put(2, 8'hFF);
        run_scan("D7 R5 R9 huge len", 0);

        for (int t = 0; t < 60; t++) begin
            build_random();
            run_scan($sformatf("RND%0d R2 R3 R5 R6", t), (t % 7) == 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #2_000_000;
        n_chk++; n_bad++;
        $display("FAIL R10 global watchdog: actual hung expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule